// File: doc/BRIEF.md
# Carrier Sense and Collision Status Generator

This block produces the two line-status signals a MAC watches on a nibble interface: a carrier indication and a collision indication. It takes transmit activity, receive activity, a duplex flag, a repeater flag and a false-carrier flag. It combines them with no clock edge in the path, so both status outputs follow their inputs asynchronously.

The collision output changes meaning with the mode. In a half-duplex end station it reports simultaneous transmit and receive. In full duplex it stays low. In repeater mode it carries the false-carrier flag. Carrier sense counts transmit activity only in half-duplex, non-repeater operation. In every other mode it follows receive activity alone.

For synchronous consumers, the block also provides a copy of both outputs delayed by one flip-flop stage.

Top module: `crs_col_gen`

## Requirements
- R1: In half-duplex, non-repeater mode (fdx_i=0, rptr_i=0), col_o is 1 exactly when tx_act_i and rx_act_i are both 1.
- R2: In full-duplex, non-repeater mode (fdx_i=1, rptr_i=0), col_o is 0 for every value of the activity and false-carrier inputs.
- R3: With rptr_i=1, col_o equals fcar_i and does not depend on tx_act_i, rx_act_i or fdx_i. The repeater meaning wins when fdx_i is also 1.
- R4: In half-duplex, non-repeater mode, crs_o is the OR of tx_act_i and rx_act_i.
- R5: When fdx_i=1 or rptr_i=1, crs_o equals rx_act_i, and tx_act_i has no effect on it.
- R6: crs_o and col_o respond to input changes within the same clock period, with no clock edge in between.
- R7: After each rising clock edge, crs_q_o and col_q_o hold the values crs_o and col_o had just before that edge. While rst_n is low, both registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered copies |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_act_i | input | 1 | Transmit activity |
| rx_act_i | input | 1 | Receive activity |
| fdx_i | input | 1 | 1 = full duplex |
| rptr_i | input | 1 | 1 = repeater mode |
| fcar_i | input | 1 | False-carrier detected |
| crs_o | output | 1 | Carrier sense, combinational |
| col_o | output | 1 | Collision or false carrier, combinational |
| crs_q_o | output | 1 | Carrier sense, delayed by one clock |
| col_q_o | output | 1 | Collision or false carrier, delayed by one clock |

## Verification
The bench drives all 32 combinations of the five inputs and compares both outputs against a truth table derived from the requirements.

The combination of repeater and full duplex is the key corner case. A design that gives full duplex priority would hold col_o low and drop the false-carrier report. Transmit-only activity in full duplex or repeater mode catches a carrier that wrongly includes the transmit side.

Outputs are sampled between edges, before the next clock, so a design that registered the status would show stale values. The delayed copies are checked against the previous cycle's inputs, which catches a missing stage or an extra one.

// File: rtl/crs_col_gen.sv
module crs_col_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act_i,
  input  logic rx_act_i,
  input  logic fdx_i,
  input  logic rptr_i,
  input  logic fcar_i,
  output logic crs_o,
  output logic col_o,
  output logic crs_q_o,
  output logic col_q_o
);

  logic rx_only;
  assign rx_only = fdx_i | rptr_i;

  assign crs_o = rx_only ? rx_act_i : (tx_act_i | rx_act_i);

  always_comb begin
    if (rptr_i)     col_o = fcar_i;
    else if (fdx_i) col_o = 1'b0;
    else            col_o = tx_act_i & rx_act_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q_o <= 1'b0;
      col_q_o <= 1'b0;
    end else begin
      crs_q_o <= crs_o;
      col_q_o <= col_o;
    end
  end

  // R1
  hdx_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fdx_i && !rptr_i && tx_act_i && rx_act_i) |-> col_o);
  // R2
  fdx_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fdx_i && !rptr_i) |-> !col_o);
  // R3
  rptr_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_i |-> (col_o == fcar_i));
  // R5
  rx_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fdx_i || rptr_i) |-> (crs_o == rx_act_i));
  // R7
  crs_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (crs_q_o == $past(crs_o)));
  // R7
  col_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (col_q_o == $past(col_o)));

endmodule

// File: tb/crs_col_gen_tb.sv
module crs_col_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx, rx, fdx, rptr, fcar;
  logic crs, col, crs_q, col_q;
  int errors = 0, checks = 0;

  crs_col_gen u_dut (.clk(clk), .rst_n(rst_n), .tx_act_i(tx), .rx_act_i(rx),
    .fdx_i(fdx), .rptr_i(rptr), .fcar_i(fcar), .crs_o(crs), .col_o(col),
    .crs_q_o(crs_q), .col_q_o(col_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (tx=%b rx=%b fdx=%b rptr=%b fcar=%b)",
               req, act, exp, tx, rx, fdx, rptr, fcar);
    end
  endtask

  function automatic logic exp_crs(logic t, logic r, logic f, logic p);
    return (f | p) ? r : (t | r);
  endfunction
  function automatic logic exp_col(logic t, logic r, logic f, logic p, logic fc);
    if (p) return fc;
    if (f) return 1'b0;
    return t & r;
  endfunction

  function automatic string crs_tag(logic f, logic p);
    return (f | p) ? "R5" : "R4";
  endfunction
  function automatic string col_tag(logic f, logic p);
    return p ? "R3" : (f ? "R2" : "R1");
  endfunction

  task automatic test_reset();
    tx = 0; rx = 0; fdx = 0; rptr = 0; fcar = 0;
    rst_n = 0;
    #(CLK_PERIOD*2 + 2);
    chk("R7 reset crs_q", crs_q, 1'b0);
    chk("R7 reset col_q", col_q, 1'b0);
    rst_n = 1;
  endtask

  task automatic test_truth_table();
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      {rptr, fdx, fcar, tx, rx} = v[4:0];
      #1;
      chk({crs_tag(fdx, rptr), " crs"}, crs, exp_crs(tx, rx, fdx, rptr));
      chk({col_tag(fdx, rptr), " col"}, col, exp_col(tx, rx, fdx, rptr, fcar));
    end
  endtask

  task automatic test_async();
    @(posedge clk); #1;
    fdx = 0; rptr = 0; fcar = 0; tx = 1; rx = 0;
    #1 chk("R6 crs rise", crs, 1'b1);
    rx = 1;
    #1 chk("R6 col rise", col, 1'b1);
    rptr = 1; fdx = 1; fcar = 1;
    #1 chk("R6 R3 col repeater+fdx", col, 1'b1);
  endtask

  task automatic test_lag();
    for (int v = 0; v < 32; v++) begin
      logic pc, pl;
      @(negedge clk);
      {rptr, fdx, fcar, tx, rx} = v[4:0] ^ 5'b10110;
      pc = exp_crs(tx, rx, fdx, rptr);
      pl = exp_col(tx, rx, fdx, rptr, fcar);
      @(posedge clk); #1;
      chk("R7 crs_q", crs_q, pc);
      chk("R7 col_q", col_q, pl);
    end
  endtask

  initial begin
    test_reset();
    test_truth_table();
    test_async();
    test_lag();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule